// File: doc/BRIEF.md
# E3 Overhead Error Injector

This block sits on the transmit byte stream of an E3 framer, after the overhead bytes have been written. On command it corrupts selected overhead bytes so that a far-end receiver or a test loop can be shown to detect the errors. Three kinds of fault are available: a framing fault in the alignment word, a parity fault in the error-monitoring byte, and a remote-error fault in the maintenance byte. All other bytes pass through untouched, one clock later.

Each kind of fault is armed by a one-cycle request and starts at the next frame start. A framing fault can flip one bit of the alignment word or overwrite the whole word with a fixed bad pattern. It can last one frame or a burst of consecutive frames. When the last corrupted frame has gone by, a one-cycle done pulse is raised for that kind. The frame position is counted from a start-of-frame marker that travels with the first byte. Only bytes marked valid are counted.

Top module: `e3oi_injector`

## Requirements
- R1: When no injection covers a byte, a valid input byte appears on `out_data` unchanged one clock later, with `out_vld` and `out_sof` copying `in_vld` and `in_vld & in_sof` from the same cycle.
- R2: The byte that comes with `in_sof` is frame offset 0, the first alignment byte. The second alignment byte is at offset 1, the error-monitoring byte at offset ROW_LEN and the maintenance byte at offset 3*ROW_LEN. Only cycles with `in_vld` high advance the offset, and an idle cycle gives `out_vld` low.
- R3: In bit mode (`cfg_word_err` = 0), a framing injection inverts bit 7 of the byte at offset 0 and leaves offset 1 unchanged.
- R4: In word mode (`cfg_word_err` = 1), a framing injection replaces offset 0 with 09h and offset 1 with D7h.
- R5: With `cfg_four_frames` = 0, a framing injection covers one frame. With it at 1, the injection covers BURST_LEN (default 4) consecutive frames.
- R6: A parity injection inverts bit 0 of the error-monitoring byte in exactly one frame.
- R7: A remote-error injection inverts bit 6 of the maintenance byte in exactly one frame. Bit 7 is the first bit sent, so bit 6 is the second bit on the line.
- R8: A request takes effect from the first frame start after the request cycle. A request that arrives together with `in_sof` leaves that frame untouched and starts at the following frame.
- R9: A request of a kind that is already pending or active is ignored. The mode and burst settings are sampled in the request cycle and held until the injection ends.
- R10: The done output of a kind pulses for one cycle together with `out_sof` of the first frame after its last injected frame.
- R11: After reset, all outputs are 0 and no injection is pending.
- R12: The three kinds run independently and can corrupt the same frames at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is frame offset 0 |
| in_data | input | 8 | Input byte |
| cfg_word_err | input | 1 | Framing fault style: 0 single bit, 1 whole word |
| cfg_four_frames | input | 1 | Framing fault length: 0 one frame, 1 burst |
| req_fas | input | 1 | Framing injection request pulse |
| req_bip | input | 1 | Parity injection request pulse |
| req_rei | input | 1 | Remote-error injection request pulse |
| out_vld | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is frame offset 0 |
| out_data | output | 8 | Output byte |
| done_fas | output | 1 | Framing injection finished |
| done_bip | output | 1 | Parity injection finished |
| done_rei | output | 1 | Remote-error injection finished |

## Verification
The bench builds the block with ROW_LEN = 4 and the default BURST_LEN = 4, so a frame is 36 bytes long. Every overhead offset, the whole four-frame burst and the done pulse after it then fit in a few hundred cycles. Because a frame is so short, each scenario can run a warm-up frame, the injected frames and several clean frames after them. Idle cycles fall between bytes, and re-requests with flipped settings arrive in the middle of an active injection, all within the same short run.

// File: rtl/e3oi_pkg.sv
package e3oi_pkg;

    localparam int KINDS   = 3;
    localparam int IDX_FAS = 0;
    localparam int IDX_BIP = 1;
    localparam int IDX_REI = 2;

    localparam logic [7:0] FA1_BAD      = 8'h09;
    localparam logic [7:0] FA2_BAD      = 8'hD7;
    localparam logic [7:0] FA1_BIT_MASK = 8'h80;
    localparam logic [7:0] EM_MASK      = 8'h01;
    localparam logic [7:0] REI_MASK     = 8'h40;

    // only the framing engine latches a mode bit that matters
    localparam logic [KINDS-1:0] MODE_USERS = 3'b001;

    typedef enum logic [1:0] {
        INJ_IDLE = 2'd0,
        INJ_PEND = 2'd1,
        INJ_ACT  = 2'd2
    } inj_state_e;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic [7:0] data;
    } e3_byte_t;

    function automatic int unsigned frames_for(input logic four, input int unsigned burst_len);
        return four ? burst_len : 1;
    endfunction

endpackage

// File: rtl/e3oi_pos.sv
module e3oi_pos #(
    parameter int FRAME_LEN = 531,
    parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic             sof,
    output logic [POS_W-1:0] pos_now
);
    localparam logic [POS_W-1:0] SENTINEL = POS_W'(FRAME_LEN);

    logic [POS_W-1:0] pos_q;

    assign pos_now = (vld && sof) ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= SENTINEL;
        end else if (vld) begin
            pos_q <= (pos_now == SENTINEL) ? SENTINEL : pos_now + 1'b1;
        end
    end

    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos_q <= SENTINEL);

    a_r2_idle_holds_pos: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(pos_q));
endmodule

// File: rtl/e3oi_engine.sv
module e3oi_engine
    import e3oi_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic req,
    input  logic four,
    input  logic mode,
    output logic hit,
    output logic mode_q,
    output logic done
);
    inj_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             four_q;

    assign hit = ((st == INJ_PEND) && sof) ||
                 ((st == INJ_ACT) && !(sof && cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= INJ_IDLE;
            cnt    <= '0;
            four_q <= 1'b0;
            mode_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                INJ_IDLE: if (req) begin
                    st     <= INJ_PEND;
                    four_q <= four;
                    mode_q <= mode;
                end
                INJ_PEND: if (sof) begin
                    st  <= INJ_ACT;
                    cnt <= CNT_W'(frames_for(four_q, BURST_LEN) - 1);
                end
                INJ_ACT: if (sof) begin
                    if (cnt == '0) begin
                        st   <= INJ_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= INJ_IDLE;
            endcase
        end
    end

    a_r10_done_after_active: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(st == INJ_ACT));

    a_r9_settings_held: assert property (@(posedge clk) disable iff (rst)
        (st != INJ_IDLE) |=> ($stable(mode_q) && $stable(four_q)));

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (st == INJ_ACT) |-> (int'(cnt) < BURST_LEN));

    a_r8_pending_waits: assert property (@(posedge clk) disable iff (rst)
        ((st == INJ_PEND) && !sof) |=> (st == INJ_PEND));
endmodule

// File: rtl/e3oi_corrupt.sv
module e3oi_corrupt
    import e3oi_pkg::*;
#(
    parameter int ROW_LEN = 59,
    parameter int POS_W   = 10
) (
    input  logic [7:0]       din,
    input  logic [POS_W-1:0] pos,
    input  logic [KINDS-1:0] hit,
    input  logic             word,
    output logic [7:0]       dout
);
    localparam logic [POS_W-1:0] OFS_FA1 = '0;
    localparam logic [POS_W-1:0] OFS_FA2 = POS_W'(1);
    localparam logic [POS_W-1:0] OFS_EM  = POS_W'(ROW_LEN);
    localparam logic [POS_W-1:0] OFS_MA  = POS_W'(3 * ROW_LEN);

    always_comb begin
        dout = din;
        if (hit[IDX_FAS] && pos == OFS_FA1) begin
            dout = word ? FA1_BAD : (din ^ FA1_BIT_MASK);
        end else if (hit[IDX_FAS] && word && pos == OFS_FA2) begin
            dout = FA2_BAD;
        end else if (hit[IDX_BIP] && pos == OFS_EM) begin
            dout = din ^ EM_MASK;
        end else if (hit[IDX_REI] && pos == OFS_MA) begin
            dout = din ^ REI_MASK;
        end
    end
endmodule

// File: rtl/e3oi_injector.sv
module e3oi_injector
    import e3oi_pkg::*;
#(
    parameter int ROW_LEN   = 59,
    parameter int ROWS      = 9,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic       in_sof,
    input  logic [7:0] in_data,
    input  logic       cfg_word_err,
    input  logic       cfg_four_frames,
    input  logic       req_fas,
    input  logic       req_bip,
    input  logic       req_rei,
    output logic       out_vld,
    output logic       out_sof,
    output logic [7:0] out_data,
    output logic       done_fas,
    output logic       done_bip,
    output logic       done_rei
);
    localparam int FRAME_LEN = ROWS * ROW_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN + 1);

    logic [POS_W-1:0] pos;
    logic             sof_tick;
    logic [KINDS-1:0] req_v, hit_raw, hit, mode_v, done_v;
    logic             word_q;
    logic [7:0]       cdata;
    e3_byte_t         obyte;

    assign sof_tick = in_vld & in_sof;
    assign req_v    = {req_rei, req_bip, req_fas};

    e3oi_pos #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_pos (
        .clk(clk), .rst(rst), .vld(in_vld), .sof(in_sof), .pos_now(pos)
    );

    for (genvar k = 0; k < KINDS; k++) begin : g_eng
        e3oi_engine #(.BURST_LEN(BURST_LEN)) u_eng (
            .clk   (clk),
            .rst   (rst),
            .sof   (sof_tick),
            .req   (req_v[k]),
            .four  ((k == IDX_FAS) ? cfg_four_frames : 1'b0),
            .mode  ((k == IDX_FAS) ? cfg_word_err : 1'b0),
            .hit   (hit_raw[k]),
            .mode_q(mode_v[k]),
            .done  (done_v[k])
        );
    end

    assign hit    = in_vld ? hit_raw : '0;
    assign word_q = |(mode_v & MODE_USERS);

    e3oi_corrupt #(.ROW_LEN(ROW_LEN), .POS_W(POS_W)) u_cor (
        .din(in_data), .pos(pos), .hit(hit), .word(word_q), .dout(cdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            obyte <= '0;
        end else begin
            obyte.vld  <= in_vld;
            obyte.sof  <= sof_tick;
            obyte.data <= in_vld ? cdata : '0;
        end
    end

    assign out_vld  = obyte.vld;
    assign out_sof  = obyte.sof;
    assign out_data = obyte.data;
    assign done_fas = done_v[IDX_FAS];
    assign done_bip = done_v[IDX_BIP];
    assign done_rei = done_v[IDX_REI];

    a_r1_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_vld && hit == '0) |=> (out_vld && out_data == $past(in_data)));

    a_r4_word_fa1: assert property (@(posedge clk) disable iff (rst)
        (in_vld && hit[IDX_FAS] && word_q && pos == '0) |=> (out_data == FA1_BAD));

    a_r6_bip_flip: assert property (@(posedge clk) disable iff (rst)
        (in_vld && hit[IDX_BIP] && pos == POS_W'(ROW_LEN))
            |=> (out_data == ($past(in_data) ^ EM_MASK)));

    a_r7_rei_flip: assert property (@(posedge clk) disable iff (rst)
        (in_vld && hit[IDX_REI] && pos == POS_W'(3 * ROW_LEN))
            |=> (out_data == ($past(in_data) ^ REI_MASK)));

    a_r10_done_with_sof: assert property (@(posedge clk) disable iff (rst)
        (done_fas || done_bip || done_rei) |-> out_sof);
endmodule

// File: tb/test_e3oi_injector.sv
module test_e3oi_injector;
    localparam int ROW   = 4;
    localparam int FLEN  = 9 * ROW;
    localparam int BURST = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_vld, in_sof, cfg_word_err, cfg_four_frames;
    logic       req_fas, req_bip, req_rei;
    logic [7:0] in_data;
    logic       out_vld, out_sof, done_fas, done_bip, done_rei;
    logic [7:0] out_data;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    e3oi_injector #(.ROW_LEN(ROW), .ROWS(9), .BURST_LEN(BURST)) i_e3oi_injector (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_data(in_data),
        .cfg_word_err(cfg_word_err), .cfg_four_frames(cfg_four_frames),
        .req_fas(req_fas), .req_bip(req_bip), .req_rei(req_rei),
        .out_vld(out_vld), .out_sof(out_sof), .out_data(out_data),
        .done_fas(done_fas), .done_bip(done_bip), .done_rei(done_rei)
    );

    // scenario table {kinds[2:0] = {rei,bip,fas}, word, four}
    localparam logic [4:0] SCEN [8] = '{
        5'b001_0_0, 5'b001_1_0, 5'b001_0_1, 5'b001_1_1,
        5'b010_0_0, 5'b100_0_0, 5'b111_1_1, 5'b111_0_0
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data(input logic [7:0] d, input int p, input int f,
                                            input logic [2:0] m, input logic w, input logic b);
        logic [7:0] r = d;
        if (f >= 0) begin
            if (m[0] && f < (b ? BURST : 1)) begin
                if (p == 0) r = w ? 8'h09 : (d ^ 8'h80);
                else if (p == 1 && w) r = 8'hD7;
            end
            if (m[1] && f == 0 && p == ROW)     r = d ^ 8'h01;
            if (m[2] && f == 0 && p == 3 * ROW) r = d ^ 8'h40;
        end
        return r;
    endfunction

    function automatic string tag_for(input int p, input int f, input logic w);
        if (p <= 1)        return (f >= 1) ? "R5" : (w ? "R4" : "R3");
        if (p == ROW)      return "R6";
        if (p == 3 * ROW)  return "R7";
        return "R1";
    endfunction

    // f: frame index relative to the injection start (negative = before it)
    task automatic drive_frame(input int f, input logic [2:0] m, input logic w, input logic b,
                               input int rq_pos, input logic [2:0] rq_m, input logic rq_w,
                               input logic rq_b, input bit gaps, input int seed);
        for (int p = 0; p < FLEN; p++) begin
            logic [7:0] d;
            logic [2:0] exp_done;
            if (gaps && (p % 5) == 2) begin
                @(negedge clk);
                in_vld = 1'b0; in_sof = 1'b0; in_data = 8'hAA;
                req_fas = 1'b0; req_bip = 1'b0; req_rei = 1'b0;
                @(posedge clk); #2;
                check(out_vld == 1'b0, "R2", int'(out_vld), 0);
            end
            d = 8'(f * 37 + p * 11 + seed * 5 + 3);
            @(negedge clk);
            in_vld = 1'b1; in_sof = (p == 0); in_data = d;
            {req_rei, req_bip, req_fas} = (p == rq_pos) ? rq_m : 3'b000;
            if (p == rq_pos) begin
                cfg_word_err = rq_w; cfg_four_frames = rq_b;
            end else if (p == rq_pos + 1) begin
                cfg_word_err = ~rq_w; cfg_four_frames = ~rq_b;  // R9 settings sampled once
            end
            @(posedge clk); #2;
            check(out_vld && out_sof == (p == 0), "R1", {out_vld, out_sof}, {1'b1, p == 0});
            check(out_data == exp_data(d, p, f, m, w, b), tag_for(p, f, w),
                  out_data, exp_data(d, p, f, m, w, b));
            exp_done[0] = m[0] && p == 0 && f == (b ? BURST : 1);
            exp_done[1] = m[1] && p == 0 && f == 1;
            exp_done[2] = m[2] && p == 0 && f == 1;
            check({done_rei, done_bip, done_fas} == exp_done, "R10",
                  {done_rei, done_bip, done_fas}, exp_done);
        end
        @(negedge clk);
        req_fas = 1'b0; req_bip = 1'b0; req_rei = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0; in_sof = 1'b0; in_data = 8'h00;
        cfg_word_err = 1'b0; cfg_four_frames = 1'b0;
        req_fas = 1'b0; req_bip = 1'b0; req_rei = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        check(out_vld == 0 && out_sof == 0 && out_data == 0, "R11",
              {out_vld, out_sof, out_data}, 0);
        check({done_rei, done_bip, done_fas} == 0, "R11", {done_rei, done_bip, done_fas}, 0);
        @(negedge clk); rst = 1'b0;
        // R11 nothing pending: a clean frame passes untouched
        drive_frame(-1, 3'b000, 1'b0, 1'b0, -1, 3'b000, 1'b0, 1'b0, 1'b0, 9);

        // table walk: request mid-frame (R8), re-request while busy (R9),
        // all kinds together in the last entries (R12)
        for (int e = 0; e < 8; e++) begin
            logic [2:0] m;
            logic w, b;
            m = SCEN[e][4:2]; w = SCEN[e][1]; b = SCEN[e][0];
            drive_frame(-1, m, w, b, 5, m, w, b, e[0], e);
            drive_frame(0, m, w, b, 3, m, ~w, ~b, 1'b0, e);
            for (int f = 1; f <= 5; f++) drive_frame(f, m, w, b, -1, 3'b000, 1'b0, 1'b0, e[1], e);
        end

        // R8 request together with the frame start: that frame stays clean
        drive_frame(-1, 3'b010, 1'b0, 1'b0, 0, 3'b010, 1'b0, 1'b0, 1'b0, 20);
        drive_frame(0, 3'b010, 1'b0, 1'b0, -1, 3'b000, 1'b0, 1'b0, 1'b0, 21);
        drive_frame(1, 3'b010, 1'b0, 1'b0, -1, 3'b000, 1'b0, 1'b0, 1'b0, 22);

        // R8 framing request at offset 0 with a burst: starts one frame later
        drive_frame(-1, 3'b001, 1'b1, 1'b1, 0, 3'b001, 1'b1, 1'b1, 1'b1, 23);
        for (int f = 0; f <= 5; f++) drive_frame(f, 3'b001, 1'b1, 1'b1, -1, 3'b000, 1'b0, 1'b0, 1'b0, 24);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule